// File: doc/BRIEF.md
# Shared Signed/Unsigned Magnitude Comparator

This block orders two N-bit operands. It raises one of three flags: greater, equal or less. A mode input decides how the operands are read. They are either plain binary magnitudes or two's-complement numbers. The block is purely combinational, and its flags follow the inputs with no clock.

Both readings agree on how to rank the N-1 bits below the top bit. A single ordering network of those low bits therefore feeds both modes. Only a small resolver at the top bit changes with the mode.

- When the top bits match, the low-bit result is passed through unchanged.
- When the top bits differ, the resolver alone decides. In unsigned mode it favours the operand whose top bit is 1. In signed mode it favours the operand whose top bit is 0.

The low network is built as a balanced tree of merge cells, so its depth grows with log2 of the width rather than linearly.

Top module: `mag_cmp_shared`

## Requirements
- R1: With is_signed = 0, gt is 1 exactly when a > b as an N-bit unsigned number, and lt is 1 exactly when a < b.
- R2: With is_signed = 1 and differing top bits (bit N-1), the operand whose top bit is 0 is reported larger.
- R3: With is_signed = 1 and equal top bits, the outcome equals an unsigned comparison of bits N-2..0 alone. This holds for two negative operands too: with N = 4, 4'b1111 > 4'b1100 > 4'b1001.
- R4: With is_signed = 0 and differing top bits, the operand whose top bit is 1 is reported larger.
- R5: eq is 1 exactly when all N bits of a and b match, in either mode.
- R6: For every input, exactly one of gt, eq and lt is 1.
- R7: With is_signed = 1, gt and lt match the two's-complement ordering of a and b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| is_signed | input | 1 | 1: operands are two's-complement; 0: unsigned |
| gt | output | 1 | a ranks above b |
| eq | output | 1 | a and b are bit-identical |
| lt | output | 1 | a ranks below b |

## Verification
The assertions assume that a, b and is_signed carry known 0/1 values. They skip any evaluation in which an input holds X or Z.

The stimulus drives every operand pair in both modes at the default width of four bits. Each combination is applied away from the clock edge and held until the outputs are sampled. This covers every sign-bit pairing and every low-bit ordering. It includes the three negative values named in R3 and the pairs that sit at the wrap point between the most positive and most negative codes.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_res_t;

endpackage

// File: rtl/mag_cmp_lowtree.sv
// Unsigned ordering of LW bits, built as a balanced tree of merge cells.
module mag_cmp_lowtree #(
    parameter int LW = 3
) (
    input  logic [LW-1:0] x,
    input  logic [LW-1:0] y,
    output logic          x_gt,
    output logic          x_eq
);
    localparam int LEVELS = (LW > 1) ? $clog2(LW) : 0;
    localparam int LEAVES = 1 << LEVELS;

    genvar lv;
    generate
        for (lv = 0; lv <= LEVELS; lv++) begin : g_lvl
            localparam int CNT = LEAVES >> lv;
            logic [CNT-1:0] gt_v;
            logic [CNT-1:0] eq_v;
            if (lv == 0) begin : g_leaf
                for (genvar i = 0; i < CNT; i++) begin : g_bit
                    if (i < LW) begin : g_real
                        assign gt_v[i] = x[i] & ~y[i];
                        assign eq_v[i] = ~(x[i] ^ y[i]);
                    end else begin : g_pad
                        // padding positions compare as equal zeros
                        assign gt_v[i] = 1'b0;
                        assign eq_v[i] = 1'b1;
                    end
                end
            end else begin : g_merge
                for (genvar j = 0; j < CNT; j++) begin : g_node
                    // child 2j+1 is the more significant half
                    assign gt_v[j] = g_lvl[lv-1].gt_v[2*j+1]
                                   | (g_lvl[lv-1].eq_v[2*j+1] & g_lvl[lv-1].gt_v[2*j]);
                    assign eq_v[j] = g_lvl[lv-1].eq_v[2*j+1] & g_lvl[lv-1].eq_v[2*j];
                end
            end
        end
    endgenerate

    assign x_gt = g_lvl[LEVELS].gt_v[0];
    assign x_eq = g_lvl[LEVELS].eq_v[0];

endmodule

// File: rtl/mag_cmp_signsel.sv
// Resolves the top bit according to mode, else forwards the low-bit result.
module mag_cmp_signsel
    import cmp_pkg::*;
(
    input  logic     a_top,
    input  logic     b_top,
    input  logic     is_signed,
    input  logic     low_gt,
    input  logic     low_eq,
    output cmp_res_t res
);
    logic a_wins;

    always_comb begin
        // unsigned: top bit 1 wins; signed: top bit 0 wins
        a_wins = a_top ^ is_signed;
        if (a_top != b_top) begin
            res.gt = a_wins;
            res.eq = 1'b0;
            res.lt = ~a_wins;
        end else begin
            res.gt = low_gt;
            res.eq = low_eq;
            res.lt = ~low_gt & ~low_eq;
        end
    end

endmodule

// File: rtl/mag_cmp_shared.sv
module mag_cmp_shared
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_signed,
    output logic             gt,
    output logic             eq,
    output logic             lt
);
    localparam int LOW_W = WIDTH - 1;
    localparam int TOP   = WIDTH - 1;

    logic     low_gt;
    logic     low_eq;
    cmp_res_t res;

    mag_cmp_lowtree #(.LW(LOW_W)) u_low (
        .x    (a[LOW_W-1:0]),
        .y    (b[LOW_W-1:0]),
        .x_gt (low_gt),
        .x_eq (low_eq)
    );

    mag_cmp_signsel u_sel (
        .a_top     (a[TOP]),
        .b_top     (b[TOP]),
        .is_signed (is_signed),
        .low_gt    (low_gt),
        .low_eq    (low_eq),
        .res       (res)
    );

    assign gt = res.gt;
    assign eq = res.eq;
    assign lt = res.lt;

endmodule

// File: rtl/mag_cmp_shared_chk.sv
module mag_cmp_shared_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             is_signed,
    input logic             gt,
    input logic             eq,
    input logic             lt
);
    localparam int TOP = WIDTH - 1;

    always_comb begin
        if (!$isunknown({a, b, is_signed})) begin
            assert_one_flag_R6: assert ($countones({gt, eq, lt}) == 1);
            assert_eq_bits_R5: assert (eq == (a == b));
            if (!is_signed) begin
                assert_unsigned_order_R1: assert ((gt == (a > b)) && (lt == (a < b)));
                if (a[TOP] != b[TOP])
                    assert_unsigned_top_R4: assert (gt == a[TOP]);
            end else begin
                assert_signed_order_R7: assert ((gt == ($signed(a) > $signed(b)))
                                             && (lt == ($signed(a) < $signed(b))));
                if (a[TOP] != b[TOP])
                    assert_signed_top_R2: assert (gt == b[TOP]);
                else
                    assert_same_sign_low_R3: assert (gt == (a[TOP-1:0] > b[TOP-1:0]));
            end
        end
    end

endmodule

bind mag_cmp_shared mag_cmp_shared_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_mag_cmp_shared.sv
module tb_mag_cmp_shared;
    localparam int W = 4;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         is_signed = 1'b0;
    logic         gt, eq, lt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mag_cmp_shared #(.WIDTH(W)) dut (
        .a(a), .b(b), .is_signed(is_signed),
        .gt(gt), .eq(eq), .lt(lt)
    );

    function automatic int as_value(input logic [W-1:0] v, input logic sgn);
        int r;
        r = int'(v);
        if (sgn && v[W-1]) r = r - SPAN;
        return r;
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d signed=%0b got gt/eq/lt=%b expected %b",
                     req, a, b, is_signed, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic sgn);
        int ia, ib;
        logic [2:0] exp;
        string ord;
        @(negedge clk);
        a = va; b = vb; is_signed = sgn;
        #2;
        ia = as_value(va, sgn);
        ib = as_value(vb, sgn);
        exp = {ia > ib, ia == ib, ia < ib};
        check("R6", {2'b00, ($countones({gt, eq, lt}) == 1)}, 3'b001);
        check("R5", {2'b00, eq}, {2'b00, (va == vb)});
        if (!sgn) ord = (va[W-1] != vb[W-1]) ? "R4" : "R1";
        else      ord = (va[W-1] != vb[W-1]) ? "R2" : "R3";
        check(ord, {gt, eq, lt}, exp);
        if (sgn) check("R7", {gt, eq, lt}, exp);
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // settled state with zero operands: equal in unsigned mode (R5)
        @(negedge clk); #2;
        check("R5", {gt, eq, lt}, 3'b010);
        // R3 named negative chain: 1111 > 1100 > 1001 in signed mode
        apply(4'b1111, 4'b1100, 1'b1);
        check("R3", {gt, eq, lt}, 3'b100);
        apply(4'b1100, 4'b1001, 1'b1);
        check("R3", {gt, eq, lt}, 3'b100);
        // R2 / R4 wrap point: 0111 against 1000 flips with mode
        apply(4'b0111, 4'b1000, 1'b1);
        check("R2", {gt, eq, lt}, 3'b100);
        apply(4'b0111, 4'b1000, 1'b0);
        check("R4", {gt, eq, lt}, 3'b001);
        // exhaustive sweep in both modes (R1..R7)
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < SPAN; i++)
                for (int j = 0; j < SPAN; j++)
                    apply(W'(i), W'(j), m[0]);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule